// File: doc/BRIEF.md
# Tagged Receive Byte Queue with Fill Threshold

This block sits between a serial frame receiver and a processor read port. The receiver pushes each recovered byte along with a 2-bit tag that marks the byte's place in its frame. The processor pops entries in arrival order. The tag of the entry at the head of the queue is visible before that entry is popped. A reader can therefore tell in advance whether the next byte opens a frame, continues one, or closes one with a good or a bad check.

The queue holds 19 entries. It raises a threshold line while 15 or more entries are stored. It holds an end-of-packet line high while any closing-tagged entry is still queued. Two sticky flags catch misuse: a push while full, and a pop while empty. All status pins are derived from the registered fill level. They change in the same cycle as the push or pop that moves them, so there is no stale window in which an empty queue looks non-empty.

The write side is valid/ready. `wr_ready` is low exactly when the queue is full. The producer is a serial receiver that cannot stall, so it may still assert `wr_valid` while `wr_ready` is low; that byte is dropped and counted as an overflow. The read side is valid/ready as well. `rd_valid` is high whenever an entry is present. Asserting `rd_ready` pops one entry at the clock edge. `rd_ready` while `rd_valid` is low is an underflow.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset, `rd_valid`=0, `wr_ready`=1, `fill_level`=0, and `thresh_irq`, `eop_pend`, `ovf_flag` and `udf_flag` are all 0.
- R2: Entries leave in push order with their data and tag intact. `rd_data`/`rd_tag` show the head entry while `rd_valid`=1, before it is popped. Tag codes: 2'b00 first byte, 2'b01 middle byte, 2'b10 last byte with good check, 2'b11 last byte with bad check.
- R3: The queue stores exactly 19 entries. After 19 pushes with no pop, `fill_level`=19 and `wr_ready`=0.
- R4: `thresh_irq` is 1 exactly while `fill_level` is 15 or more.
- R5: A push while full is dropped: `fill_level` and the queued data are unchanged, and `ovf_flag` becomes 1 and stays 1.
- R6: A one-cycle `stat_clr` pulse clears `ovf_flag` and `udf_flag`. A new overflow or underflow event in the same cycle wins over the clear.
- R7: A pop while empty changes no pointer and sets `udf_flag`. `rd_data`/`rd_tag` keep the value of the last entry actually popped. A later push is then read normally.
- R8: `eop_pend` is 1 while at least one entry tagged last (tag bit 1 set) is stored, and drops in the cycle after the last such entry is popped.
- R9: `rd_valid`, `wr_ready` and `fill_level` reflect a push or pop in the cycle right after its clock edge. Popping the final entry makes `rd_valid` 0 at once.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave `fill_level` unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Receiver offers a byte |
| wr_data | input | 8 | Byte from the receiver |
| wr_tag | input | 2 | Frame-position tag for the byte |
| wr_ready | output | 1 | Queue has room; a push without it is an overflow |
| rd_ready | input | 1 | Reader pops the head entry |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 8 | Head byte, or last popped byte when empty |
| rd_tag | output | 2 | Tag of the head byte, or of the last popped byte when empty |
| fill_level | output | 5 | Number of stored entries |
| thresh_irq | output | 1 | Fill level at or above 15 |
| eop_pend | output | 1 | A last-tagged entry is queued |
| stat_clr | input | 1 | Status read: clears the sticky flags |
| ovf_flag | output | 1 | Sticky: push while full |
| udf_flag | output | 1 | Sticky: pop while empty |

## Verification
A short frame with first, middle and last tags checks that the head tag appears before each pop. The same frame shows `eop_pend` tracking only the closing entry. A fill to 19 followed by one extra push separates a correct capacity from an off-by-one, and the threshold is checked at the 14/15 boundary in both directions. A full drain after the overflow shows that the dropped byte did not corrupt the queue. Pops on an empty queue, and combined push-and-pop cycles, show that neither pointer moves on misuse and that order survives concurrent traffic.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    TAG_FIRST    = 2'b00,
    TAG_MID      = 2'b01,
    TAG_LAST_OK  = 2'b10,
    TAG_LAST_BAD = 2'b11
  } pos_tag_e;

  function automatic logic tag_closes(input logic [1:0] t);
    return t[1];
  endfunction
endpackage

// File: rtl/rxf_ptr.sv
module rxf_ptr #(
  parameter int DEPTH = 19,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (adv)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 19,
  parameter int EW    = 10,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wentry,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rentry
);
  logic [EW-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we && waddr == AW'(i)) cells[i] <= wentry;
    end
  end

  assign rentry = cells[raddr];
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DEPTH  = 19,
  parameter int DW     = 8,
  parameter int THRESH = 15,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    wr_tag,
  output logic          wr_ready,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    rd_tag,
  output logic [CW-1:0] fill_level,
  output logic          thresh_irq,
  output logic          eop_pend,
  input  logic          stat_clr,
  output logic          ovf_flag,
  output logic          udf_flag
);
  import rxf_pkg::*;

  localparam int EW = DW + 2;
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] THR_LVL  = CW'(THRESH);

  logic [CW-1:0] count, last_cnt;
  logic [AW-1:0] wptr, rptr;
  logic [EW-1:0] head, held;
  logic          full, empty, push, pop;

  assign full  = (count == FULL_LVL);
  assign empty = (count == '0);
  assign push  = wr_valid && !full;
  assign pop   = rd_ready && !empty;

  rxf_ptr #(.DEPTH(DEPTH)) u_wptr (.clk(clk), .rst_n(rst_n), .adv(push), .ptr(wptr));
  rxf_ptr #(.DEPTH(DEPTH)) u_rptr (.clk(clk), .rst_n(rst_n), .adv(pop),  .ptr(rptr));

  rxf_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .we(push), .waddr(wptr), .wentry({wr_tag, wr_data}),
    .raddr(rptr), .rentry(head)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      last_cnt <= '0;
      held     <= '0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      case ({push && tag_closes(wr_tag), pop && tag_closes(head[EW-1 -: 2])})
        2'b10:   last_cnt <= last_cnt + 1'b1;
        2'b01:   last_cnt <= last_cnt - 1'b1;
        default: last_cnt <= last_cnt;
      endcase
      if (pop) held <= head;
      ovf_flag <= (ovf_flag && !stat_clr) || (wr_valid && full);
      udf_flag <= (udf_flag && !stat_clr) || (rd_ready && empty);
    end
  end

  assign wr_ready   = !full;
  assign rd_valid   = !empty;
  assign rd_data    = empty ? held[DW-1:0]    : head[DW-1:0];
  assign rd_tag     = empty ? held[EW-1 -: 2] : head[EW-1 -: 2];
  assign fill_level = count;
  assign thresh_irq = (count >= THR_LVL);
  assign eop_pend   = (last_cnt != '0);

  // R3
  level_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_LVL);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && !rd_ready) |=> ($stable(count) && $stable(wptr) && ovf_flag));

  // R7
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_ready && !wr_valid) |=> ($stable(rptr) && udf_flag && $stable(rd_data)));

  // R8
  eop_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_pend |-> (last_cnt <= count));

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !(wr_valid && full) && !(rd_ready && empty)) |=> (!ovf_flag && !udf_flag));

  // R10
  concurrent_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_ready && !full && !empty) |=> $stable(count));
endmodule

// File: tb/sim_rx_tag_fifo.sv
module sim_rx_tag_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, rd_ready = 1'b0, stat_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wr_tag = '0;
  logic       wr_ready, rd_valid, thresh_irq, eop_pend, ovf_flag, udf_flag;
  logic [7:0] rd_data;
  logic [1:0] rd_tag;
  logic [4:0] fill_level;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_tag_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_tag(wr_tag),
    .wr_ready(wr_ready), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_tag(rd_tag), .fill_level(fill_level), .thresh_irq(thresh_irq), .eop_pend(eop_pend),
    .stat_clr(stat_clr), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit wv, input logic [7:0] wd, input logic [1:0] wt,
                     input bit rr, input bit sc);
    @(negedge clk);
    wr_valid = wv; wr_data = wd; wr_tag = wt; rd_ready = rr; stat_clr = sc;
    @(posedge clk); #1;
    wr_valid = 0; rd_ready = 0; stat_clr = 0;
  endtask

  task automatic t_reset;
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 level", fill_level, 0);
    chk("R1 flags", {thresh_irq, eop_pend, ovf_flag, udf_flag}, 0);
  endtask

  task automatic t_frame;
    cyc(1, 8'hA0, 2'b00, 0, 0);
    cyc(1, 8'hA1, 2'b01, 0, 0);
    chk("R8 no close yet", eop_pend, 0);
    cyc(1, 8'hA2, 2'b10, 0, 0);
    chk("R9 level 3", fill_level, 3);
    chk("R8 eop set", eop_pend, 1);
    chk("R2 head tag first", rd_tag, 0);
    chk("R2 head data", rd_data, 8'hA0);
    cyc(0, 0, 0, 1, 0);
    chk("R2 head tag mid", rd_tag, 1);
    chk("R2 data 2", rd_data, 8'hA1);
    cyc(0, 0, 0, 1, 0);
    chk("R2 head tag last", rd_tag, 2);
    chk("R2 data 3", rd_data, 8'hA2);
    chk("R8 still pending", eop_pend, 1);
    cyc(0, 0, 0, 1, 0);
    chk("R9 empty at once", rd_valid, 0);
    chk("R8 eop cleared", eop_pend, 0);
  endtask

  task automatic t_underflow;
    cyc(0, 0, 0, 1, 0);
    chk("R7 udf set", udf_flag, 1);
    chk("R7 data held", rd_data, 8'hA2);
    chk("R7 tag held", rd_tag, 2);
    chk("R7 level", fill_level, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R6 udf cleared", udf_flag, 0);
    cyc(1, 8'h55, 2'b11, 0, 0);
    chk("R7 new data", rd_data, 8'h55);
    chk("R7 new tag", rd_tag, 3);
    cyc(0, 0, 0, 1, 0);
    chk("R7 drained", rd_valid, 0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 14; i++) cyc(1, 8'(8'h10 + i), 2'b01, 0, 0);
    chk("R4 below 15", thresh_irq, 0);
    cyc(1, 8'h1E, 2'b01, 0, 0);
    chk("R4 at 15", thresh_irq, 1);
    for (int i = 15; i < 19; i++) cyc(1, 8'(8'h10 + i), 2'b01, 0, 0);
    chk("R3 level 19", fill_level, 19);
    chk("R3 full", wr_ready, 0);
    cyc(1, 8'hEE, 2'b10, 0, 0);
    chk("R5 ovf set", ovf_flag, 1);
    chk("R5 level kept", fill_level, 19);
    chk("R5 no eop from drop", eop_pend, 0);
    for (int i = 0; i < 19; i++) begin
      chk("R5 content", rd_data, 8'h10 + i);
      cyc(0, 0, 0, 1, 0);
      if (i == 3) chk("R4 at 15 going down", thresh_irq, 1);
      if (i == 4) chk("R4 at 14 going down", thresh_irq, 0);
    end
    chk("R5 ovf sticky", ovf_flag, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R6 ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_concurrent;
    cyc(1, 8'h71, 2'b00, 0, 0);
    cyc(1, 8'h72, 2'b10, 0, 0);
    cyc(1, 8'h73, 2'b01, 1, 0);
    chk("R10 level kept", fill_level, 2);
    chk("R10 next data", rd_data, 8'h72);
    chk("R10 eop", eop_pend, 1);
    cyc(0, 0, 0, 1, 0);
    chk("R10 third", rd_data, 8'h73);
    chk("R8 eop dropped", eop_pend, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R9 empty", rd_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_frame();
    t_underflow();
    t_fill();
    t_concurrent();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule